// File: doc/BRIEF.md
# Banked Pseudo-Dual-Port Memory

This block is a word-addressed memory with one read port and one write port. Its storage is split into a power-of-two number of single-ported banks. Each cycle a read and a write can both proceed, provided they land in different banks. A bank-select function taken from the address steers every request to a bank. That function is fixed at elaboration: fine interleave (neighbouring words sit in neighbouring banks) or coarse split (each bank owns one contiguous slice of the address space). Either mode can fold extra address bits into the select by XOR, which spreads strided traffic that would otherwise pile onto one bank.

When the read and the write want the same bank in the same cycle, the read is served and the write is parked in a two-entry write buffer. Parked writes retire in arrival order on any later cycle in which the read side leaves their bank alone. Reads never wait: data appears exactly one cycle after the request. Reads that hit a parked write see its bytes, merged by byte enable over the bank contents. When the buffer is full, write-ready drops and the writer holds its request. No request is ever discarded.

Top module: `banked_pdp_ram`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wr_ready` is 1 and `rd_data_valid` is 0.
- R2: `rd_data_valid` is 1 in the cycle after a cycle with `rd_valid` high and 0 otherwise. `rd_data` then holds the word most recently written at `rd_addr` before the request cycle.
- R3: Bit i of `wr_be` governs byte i of the word (data bits 8i+7 down to 8i). Bytes whose enable is 0 keep their previous value.
- R4: In fine-interleave mode without hashing, the bank of an address is its three lowest bits.
- R5: In coarse mode without hashing, the bank of an address is its three highest bits (with the default 8-bit address).
- R6: With hashing enabled in fine mode, the bank is the three lowest address bits XOR address bits 5..3.
- R7: A read is never delayed or altered by a write to the same bank. The read keeps its one-cycle latency while the write is deferred.
- R8: A write that collides with a read on its bank is buffered. With two writes outstanding, `wr_ready` is 0 and stays 0 while the blocking reads continue. Every accepted write eventually lands.
- R9: A read of an address with writes still buffered returns the bank word with the buffered bytes merged in, oldest entry first, newest last.
- R10: Buffered writes retire in arrival order whenever their bank is not being read. Once reads stop, `wr_ready` returns to 1 within two cycles.
- R11: A read and a write to the same address in the same cycle return the old word. The new word is visible to the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Read word address |
| wr_valid | input | 1 | Write request this cycle |
| wr_ready | output | 1 | Write accepted when high with `wr_valid` |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Byte enables of the write |
| rd_data | output | DATA_W | Read data, one cycle after the request |
| rd_data_valid | output | 1 | `rd_data` carries a result |

## Verification
The bench drives three instances in lockstep: fine, coarse and hashed fine. It holds a stream of reads on one bank while writing a chosen address. A wrong bank-select function then shows up as `wr_ready` falling on an instance that should have had no collision, or staying high on one that should have. While the buffer is full and blocked, the bench reads the buffered address. That exposes a missing forward or a merge in the wrong order: stale data, or the older write's bytes winning. It then stops the reads and checks that `wr_ready` recovers and that the final word equals the older write overlaid by the newer one. A design that drained out of order or lost a stalled write would fail that check.

// File: rtl/banked_pdp_pkg.sv
package banked_pdp_pkg;

   // How address bits choose a bank
   typedef enum logic [0:0] {
      MAP_FINE   = 1'b0,   // low-order bits pick the bank
      MAP_COARSE = 1'b1    // high-order bits pick the bank
   } bank_map_e;

endpackage

// File: rtl/bpdp_bank_map.sv
module bpdp_bank_map
   import banked_pdp_pkg::*;
#(
   parameter int        ADDR_W   = 8,
   parameter int        BANK_W   = 3,
   parameter bank_map_e MAP_MODE = MAP_FINE,
   parameter bit        HASH_EN  = 1'b0,
   localparam int       ROW_W    = ADDR_W - BANK_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row
);

   logic [BANK_W-1:0] base;

   generate
      if (MAP_MODE == MAP_FINE) begin : g_fine
         assign base = addr[BANK_W-1:0];
         assign row  = addr[ADDR_W-1:BANK_W];
      end else begin : g_coarse
         assign base = addr[ADDR_W-1 -: BANK_W];
         assign row  = addr[ROW_W-1:0];
      end

      if (HASH_EN) begin : g_hash
         logic [BANK_W-1:0] mix;
         if (MAP_MODE == MAP_FINE) begin : g_mix_fine
            assign mix = addr[2*BANK_W-1:BANK_W];
         end else begin : g_mix_coarse
            assign mix = addr[BANK_W-1:0];
         end
         // the row keeps the unhashed bits, so the mapping stays one-to-one
         assign bank = base ^ mix;
      end else begin : g_plain
         assign bank = base;
      end
   endgenerate

endmodule

// File: rtl/bpdp_bank.sv
module bpdp_bank #(
   parameter int  ROW_W  = 5,
   parameter int  DATA_W = 64,
   localparam int BE_W   = DATA_W / 8,
   localparam int ROWS   = 1 << ROW_W
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   be,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] mem [ROWS];

   // single port: one read or one write per cycle
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            for (int j = 0; j < BE_W; j++) begin
               if (be[j]) mem[row][j*8 +: 8] <= wdata[j*8 +: 8];
            end
         end else begin
            q <= mem[row];
         end
      end
   end

endmodule

// File: rtl/bpdp_wbuf.sv
module bpdp_wbuf #(
   parameter int  ADDR_W = 8,
   parameter int  DATA_W = 64,
   parameter int  DEPTH  = 2,
   localparam int BE_W   = DATA_W / 8,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic [BE_W-1:0]   push_be,
   input  logic              pop,
   output logic              full,
   output logic              empty,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic [BE_W-1:0]   head_be,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic [BE_W-1:0]   fwd_mask,
   output logic [DATA_W-1:0] fwd_data
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("bpdp_wbuf: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [DATA_W-1:0] e_data [DEPTH];
   logic [BE_W-1:0]   e_be   [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         e_addr[wr_ptr] <= push_addr;
         e_data[wr_ptr] <= push_data;
         e_be[wr_ptr]   <= push_be;
      end
   end

   assign full      = (count == CNT_W'(DEPTH));
   assign empty     = (count == '0);
   assign head_addr = e_addr[rd_ptr];
   assign head_data = e_data[rd_ptr];
   assign head_be   = e_be[rd_ptr];

   // walk oldest to newest so later entries override earlier bytes
   always_comb begin
      logic [PTR_W-1:0] idx;
      fwd_mask = '0;
      fwd_data = '0;
      idx      = '0;
      for (int i = 0; i < DEPTH; i++) begin
         idx = rd_ptr + PTR_W'(i);
         if (CNT_W'(i) < count && e_addr[idx] == lk_addr) begin
            for (int j = 0; j < BE_W; j++) begin
               if (e_be[idx][j]) begin
                  fwd_mask[j]         = 1'b1;
                  fwd_data[j*8 +: 8]  = e_data[idx][j*8 +: 8];
               end
            end
         end
      end
   end

endmodule

// File: rtl/banked_pdp_ram.sv
module banked_pdp_ram
   import banked_pdp_pkg::*;
#(
   parameter int        ADDR_W    = 8,
   parameter int        DATA_W    = 64,
   parameter int        NUM_BANKS = 8,
   parameter int        WB_DEPTH  = 2,
   parameter bank_map_e MAP_MODE  = MAP_FINE,
   parameter bit        HASH_EN   = 1'b0,
   localparam int       BANK_W    = $clog2(NUM_BANKS),
   localparam int       ROW_W     = ADDR_W - BANK_W,
   localparam int       BE_W      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BE_W-1:0]   wr_be,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_valid
);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("banked_pdp_ram: NUM_BANKS must be a power of two, at least 2");
      end
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("banked_pdp_ram: DATA_W must be whole bytes");
      end
      if (ADDR_W < 2 * BANK_W) begin : g_bad_addr
         $error("banked_pdp_ram: ADDR_W too narrow for bank hashing");
      end
   endgenerate

   // ---------------- bank selection for the three address sources
   logic [BANK_W-1:0] rd_bank, wr_bank, hd_bank;
   logic [ROW_W-1:0]  rd_row,  wr_row,  hd_row;

   logic              buf_full, buf_empty;
   logic [ADDR_W-1:0] hd_addr;
   logic [DATA_W-1:0] hd_data;
   logic [BE_W-1:0]   hd_be;
   logic [BE_W-1:0]   fwd_mask;
   logic [DATA_W-1:0] fwd_data;

   bpdp_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAP_MODE(MAP_MODE), .HASH_EN(HASH_EN))
      u_map_rd (.addr(rd_addr), .bank(rd_bank), .row(rd_row));
   bpdp_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAP_MODE(MAP_MODE), .HASH_EN(HASH_EN))
      u_map_wr (.addr(wr_addr), .bank(wr_bank), .row(wr_row));
   bpdp_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAP_MODE(MAP_MODE), .HASH_EN(HASH_EN))
      u_map_hd (.addr(hd_addr), .bank(hd_bank), .row(hd_row));

   // ---------------- write arbitration: read has the bank first
   logic wr_fire, in_blocked, hd_blocked, direct, drain, push;

   assign wr_ready   = !buf_full;
   assign wr_fire    = wr_valid && wr_ready;
   assign hd_blocked = rd_valid && (rd_bank == hd_bank);
   assign in_blocked = rd_valid && (rd_bank == wr_bank);
   assign drain      = !buf_empty && !hd_blocked;
   // bypass only with an empty buffer, which keeps arrival order
   assign direct     = wr_fire && buf_empty && !in_blocked;
   assign push       = wr_fire && !direct;

   bpdp_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (wr_addr),
      .push_data (wr_data),
      .push_be   (wr_be),
      .pop       (drain),
      .full      (buf_full),
      .empty     (buf_empty),
      .head_addr (hd_addr),
      .head_data (hd_data),
      .head_be   (hd_be),
      .lk_addr   (rd_addr),
      .fwd_mask  (fwd_mask),
      .fwd_data  (fwd_data)
   );

   // one bank write per cycle: buffer head or bypassing request
   logic              commit_en;
   logic [BANK_W-1:0] commit_bank;
   logic [ROW_W-1:0]  commit_row;
   logic [DATA_W-1:0] commit_data;
   logic [BE_W-1:0]   commit_be;

   assign commit_en   = drain || direct;
   assign commit_bank = drain ? hd_bank : wr_bank;
   assign commit_row  = drain ? hd_row  : wr_row;
   assign commit_data = drain ? hd_data : wr_data;
   assign commit_be   = drain ? hd_be   : wr_be;

   // ---------------- bank array
   logic [NUM_BANKS-1:0] bank_rd, bank_we;
   logic [DATA_W-1:0]    bank_q [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_rd[b] = rd_valid  && (rd_bank == BANK_W'(b));
         assign bank_we[b] = commit_en && (commit_bank == BANK_W'(b));

         bpdp_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .en    (bank_rd[b] || bank_we[b]),
            .we    (bank_we[b]),
            .row   (bank_we[b] ? commit_row : rd_row),
            .wdata (commit_data),
            .be    (commit_be),
            .q     (bank_q[b])
         );
      end
   endgenerate

   // ---------------- read return stage
   logic              rd_v_q;
   logic [BANK_W-1:0] rd_bank_q;
   logic [BE_W-1:0]   fwd_mask_q;
   logic [DATA_W-1:0] fwd_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_v_q <= 1'b0;
      else        rd_v_q <= rd_valid;
   end

   always_ff @(posedge clk) begin
      rd_bank_q  <= rd_bank;
      fwd_mask_q <= fwd_mask;
      fwd_data_q <= fwd_data;
   end

   always_comb begin
      logic [DATA_W-1:0] raw;
      raw = bank_q[rd_bank_q];
      for (int j = 0; j < BE_W; j++) begin
         rd_data[j*8 +: 8] = fwd_mask_q[j] ? fwd_data_q[j*8 +: 8] : raw[j*8 +: 8];
      end
   end

   assign rd_data_valid = rd_v_q;

endmodule

// File: rtl/banked_pdp_ram_chk.sv
module banked_pdp_ram_chk #(
   parameter int NUM_BANKS = 8,
   parameter int WB_DEPTH  = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rd_valid,
   input logic                 rd_data_valid,
   input logic                 wr_valid,
   input logic                 wr_ready,
   input logic [NUM_BANKS-1:0] bank_rd,
   input logic [NUM_BANKS-1:0] bank_we
);

   // writes accepted at the port but not yet committed to a bank
   int occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= 0;
      else        occ <= occ + int'(wr_valid && wr_ready) - $countones(bank_we);
   end

   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_data_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !rd_data_valid);

   a_r7_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_rd & bank_we) == '0);

   a_r8_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ >= 0 && occ <= WB_DEPTH);

   a_r8_ready_with_room: assert property (@(posedge clk) disable iff (!rst_n)
      (occ < WB_DEPTH) |-> wr_ready);

   a_r10_drain_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (occ != 0 && !rd_valid) |-> ($countones(bank_we) == 1));

endmodule

bind banked_pdp_ram banked_pdp_ram_chk #(.NUM_BANKS(NUM_BANKS), .WB_DEPTH(WB_DEPTH)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_valid      (rd_valid),
   .rd_data_valid (rd_data_valid),
   .wr_valid      (wr_valid),
   .wr_ready      (wr_ready),
   .bank_rd       (bank_rd),
   .bank_we       (bank_we)
);

// File: tb/banked_pdp_ram_tb_top.sv
module banked_pdp_ram_tb_top;
   import banked_pdp_pkg::*;

   localparam int AW = 8;
   localparam int DW = 64;
   localparam int BW = DW / 8;
   localparam int NI = 3;   // 0: fine, 1: coarse, 2: fine + hash

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [BW-1:0] wr_be = '0;

   logic [DW-1:0] rdata  [NI];
   logic          rvalid [NI];
   logic          wready [NI];

   logic [DW-1:0] ref_mem [1 << AW];
   int n_chk  = 0;
   int n_fail = 0;
   string map_tag [NI] = '{"R4", "R5", "R6"};

   always #5 clk = ~clk;

   banked_pdp_ram #(.MAP_MODE(MAP_FINE), .HASH_EN(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .wr_valid(wr_valid), .wr_ready(wready[0]), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_data(rdata[0]), .rd_data_valid(rvalid[0]));

   banked_pdp_ram #(.MAP_MODE(MAP_COARSE), .HASH_EN(1'b0)) dut_coarse_i (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .wr_valid(wr_valid), .wr_ready(wready[1]), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_data(rdata[1]), .rd_data_valid(rvalid[1]));

   banked_pdp_ram #(.MAP_MODE(MAP_FINE), .HASH_EN(1'b1)) dut_hash_i (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .wr_valid(wr_valid), .wr_ready(wready[2]), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_data(rdata[2]), .rd_data_valid(rvalid[2]));

   // bank functions as the requirements state them
   function automatic int bank_of(input int inst, input int a);
      case (inst)
         0:       return a & 7;                       // R4
         1:       return (a >> 5) & 7;                // R5
         default: return (a & 7) ^ ((a >> 3) & 7);    // R6
      endcase
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, new_w, input logic [BW-1:0] be);
      logic [DW-1:0] r;
      r = old_w;
      for (int j = 0; j < BW; j++) if (be[j]) r[j*8 +: 8] = new_w[j*8 +: 8];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic write1(input int a, input logic [DW-1:0] d, input logic [BW-1:0] be);
      @(negedge clk);
      for (int i = 0; i < NI; i++) chk("R8 ready before write", 64'(wready[i]), 64'd1);
      wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d; wr_be = be;
      @(negedge clk);
      wr_valid = 1'b0;
      ref_mem[a] = merge(ref_mem[a], d, be);
   endtask

   task automatic read_chk(input int a, input string tag);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_valid = 1'b0;
      for (int i = 0; i < NI; i++) begin
         chk({tag, " valid"}, 64'(rvalid[i]), 64'd1);
         chk({tag, " data"}, rdata[i], ref_mem[a]);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
         chk("R1 ready in reset", 64'(wready[i]), 64'd1);
         chk("R1 valid in reset", 64'(rvalid[i]), 64'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
         chk("R1 ready after reset", 64'(wready[i]), 64'd1);
         chk("R1 valid after reset", 64'(rvalid[i]), 64'd0);
      end
   endtask

   task automatic t_basic();
      write1(0, 64'h0123_4567_89AB_CDEF, 8'hFF);
      write1(5, 64'hFEDC_BA98_7654_3210, 8'hFF);
      write1(20, 64'h1111_2222_3333_4444, 8'hFF);
      read_chk(5, "R2 read word 5");
      @(negedge clk);
      for (int i = 0; i < NI; i++) chk("R2 no valid without read", 64'(rvalid[i]), 64'd0);
      read_chk(0, "R2 read word 0");
      write1(5, 64'hAAAA_BBBB_CCCC_DDDD, 8'h3C);
      read_chk(5, "R3 byte enables");
   endtask

   // reads hammer address p while two writes go to q
   task automatic t_conflict(input int p, input int q, input logic [DW-1:0] d1, input logic [DW-1:0] d2,
                             input logic [BW-1:0] be2);
      bit exp_full [NI];
      for (int i = 0; i < NI; i++) exp_full[i] = (bank_of(i, p) == bank_of(i, q));
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = AW'(p);
      wr_valid = 1'b1; wr_addr = AW'(q); wr_data = d1; wr_be = 8'hFF;
      @(negedge clk);
      wr_data = d2; wr_be = be2;
      for (int i = 0; i < NI; i++) begin
         chk("R7 read under write valid", 64'(rvalid[i]), 64'd1);
         chk("R7 read under write data", rdata[i], ref_mem[p]);
      end
      @(negedge clk);
      wr_valid = 1'b0;
      ref_mem[q] = merge(d1, d2, be2);
      for (int i = 0; i < NI; i++)
         chk({"R8 ", map_tag[i], " ready after two writes"}, 64'(wready[i]), 64'(!exp_full[i]));
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
         chk({"R8 ", map_tag[i], " stall held"}, 64'(wready[i]), 64'(!exp_full[i]));
         chk("R7 read data during stall", rdata[i], ref_mem[p]);
      end
      rd_addr = AW'(q);
      @(negedge clk);
      rd_valid = 1'b0;
      for (int i = 0; i < NI; i++) chk({"R9 forward ", map_tag[i]}, rdata[i], ref_mem[q]);
      @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < NI; i++) chk("R10 ready after drain", 64'(wready[i]), 64'd1);
      read_chk(q, "R10 final order");
   endtask

   task automatic t_same_cycle();
      logic [DW-1:0] old_w;
      old_w = ref_mem[20];
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = AW'(20);
      wr_valid = 1'b1; wr_addr = AW'(20); wr_data = 64'h5A5A_5A5A_0F0F_0F0F; wr_be = 8'hFF;
      @(negedge clk);
      rd_valid = 1'b0; wr_valid = 1'b0;
      ref_mem[20] = 64'h5A5A_5A5A_0F0F_0F0F;
      for (int i = 0; i < NI; i++) chk("R11 old word on same cycle", rdata[i], old_w);
      read_chk(20, "R11 new word next read");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < (1 << AW); a++) ref_mem[a] = '0;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_conflict(0, 8, 64'hDEAD_BEEF_0000_0001, 64'h1234_5678_9ABC_DEF0, 8'h0F);
      t_conflict(0, 1, 64'hCAFE_F00D_0000_0002, 64'h0BAD_0BAD_0BAD_0BAD, 8'hF0);
      t_conflict(0, 9, 64'h7777_6666_5555_4444, 64'h0102_0304_0506_0708, 8'h81);
      t_same_cycle();
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule